// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block is the host-facing access logic of a byte-wide peripheral. A host reaches eight internal registers through a three-bit address, an eight-bit data path and active-low control lines. The block turns each host access into exactly one single-cycle read or write enable toward the register file. During a read it drives the fetched byte back toward the host. The register contents are outside this block. A register file hangs off `reg_addr_o`, `reg_rd_o`, `reg_wr_o`, `reg_wdata_o` and `reg_rdata_i`. The read data is taken as a combinational function of `reg_addr_o`.

A static mode input selects one of two bus styles. In strobe mode (`bus_mode_i` = 1), the host uses separate active-low read and write strobes qualified by chip select. In direction mode (`bus_mode_i` = 0), the host opens an access window by pulling chip select low, and the `wr_n_i` pin gives the direction. The same mode input also sets how the interrupt pin behaves. In strobe mode the pin is an active-high output, driven only when the modem-control enable bit is set. In direction mode it is an active-low open-drain output. The bidirectional data bus and the interrupt pin are each brought out as a drive value plus an output enable.

All control inputs pass through a two-flop synchronizer, and the address and data travel through the same stages so that they stay aligned with the strobes. A five-state machine walks each access:
- `ST_IDLE` goes to `ST_FETCH` on a read start, or to `ST_WRITE` on a write start. Read wins if both are seen.
- `ST_FETCH` always goes to `ST_READ`.
- `ST_READ` returns to `ST_IDLE` when the access ends.
- `ST_WRITE` goes to `ST_COMMIT` when the access ends.
- `ST_COMMIT` always returns to `ST_IDLE`.

Top module: `hbus_host_port`

## Requirements
- R1: `bus_mode_i` = 1 selects strobe mode and `bus_mode_i` = 0 selects direction mode. The mode is sampled through the synchronizer and latched at the start of each access, so it may only change while the bus is idle.
- R2: In strobe mode, with `cs_n_i` low and `rd_n_i` low, the block issues one `reg_rd_o` pulse with `reg_addr_o` equal to `addr_i`. The pulse appears after the third rising edge following the strobe fall. From the next edge, `data_oe_o` is 1 and `data_o` holds the byte read.
- R3: In strobe mode, with `cs_n_i` low and `wr_n_i` low, no write is issued while the strobe is low. After `wr_n_i` rises, one `reg_wr_o` pulse carries `addr_i` and the byte that was on `data_i` while the strobe was still low.
- R4: While `cs_n_i` is high, activity on `rd_n_i` and `wr_n_i` produces no `reg_rd_o`, no `reg_wr_o` and no bus drive, in either mode.
- R5: In direction mode, `cs_n_i` low with `wr_n_i` = 1 is a read. It behaves as in R2 and ends when `cs_n_i` rises.
- R6: In direction mode, `cs_n_i` low with `wr_n_i` = 0 is a write. It commits one `reg_wr_o` pulse only after `cs_n_i` rises, carrying the address and the byte present while `cs_n_i` was low.
- R7: In direction mode, `rd_n_i` has no effect. Pulling it low during a write window produces no read pulse and no bus drive.
- R8: After the host ends a read, `data_oe_o` stays 1 through the second rising edge after the release and is 0 after the third. This is one clock after the synchronized end of the access.
- R9: In strobe mode, `irq_oe_o` equals `irq_gate_i` and `irq_drv_o` equals `irq_pending_i`. The pin is tri-stated when the gate bit is 0.
- R10: In direction mode, `irq_drv_o` is always 0 and `irq_oe_o` equals `irq_pending_i`. This gives an active-low open-drain pin.
- R11: Each access yields exactly one enable pulse, however long the strobe or window is held. `reg_rd_o` and `reg_wr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode_i | input | 1 | 1: strobe mode, 0: direction mode |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low (strobe mode only) |
| wr_n_i | input | 1 | Write strobe (strobe mode) or direction, 1 = read (direction mode) |
| addr_i | input | 3 | Register address |
| data_i | input | 8 | Data bus input side |
| data_o | output | 8 | Data bus drive value |
| data_oe_o | output | 1 | Data bus output enable |
| reg_rd_o | output | 1 | Single-cycle register read enable |
| reg_wr_o | output | 1 | Single-cycle register write enable |
| reg_addr_o | output | 3 | Register address of the current access |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |
| irq_pending_i | input | 1 | Interrupt pending from the core |
| irq_gate_i | input | 1 | Modem-control interrupt output enable bit |
| irq_drv_o | output | 1 | Interrupt pin drive value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
Directed reads and writes are run in both modes.
- Strobes pulsed with chip select high show that chip select gates every access.
- Pulling `rd_n_i` low inside a direction-mode write window shows that this pin is ignored in that mode.
- During writes, the data bus is changed right after release. This shows that the committed byte is the one present during the access, not the one after it.
- Long strobes show that a held access still gives a single pulse.
- Sampling the bus enable on the second and third edges after release pins down its exact fall.

A seeded random run then mixes modes, directions, addresses, data and hold lengths against a register model kept by the bench.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_READ   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_COMMIT = 3'd4
    } acc_state_t;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hbus_access_fsm.sv
module hbus_access_fsm
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_s,
    input  logic              cs_n_s,
    input  logic              rd_n_s,
    input  logic              wr_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_oe_o
);

    acc_state_t        state_q, state_d;
    logic              mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_go, wr_go, rd_hold, wr_hold;

    // Start and continuation conditions for both bus styles
    always_comb begin
        rd_go   = !cs_n_s && (mode_s ? !rd_n_s : wr_n_s);
        wr_go   = !cs_n_s && !wr_n_s;
        rd_hold = !cs_n_s && (mode_q ? !rd_n_s : 1'b1);
        wr_hold = !cs_n_s && (mode_q ? !wr_n_s : 1'b1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_go)      state_d = ST_FETCH;
                else if (wr_go) state_d = ST_WRITE;
            end
            ST_FETCH:  state_d = ST_READ;
            ST_READ:   if (!rd_hold) state_d = ST_IDLE;
            ST_WRITE:  if (!wr_hold) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Access context: mode, address and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b1;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && (rd_go || wr_go)) begin
                mode_q <= mode_s;
                addr_q <= addr_s;
            end
            if ((state_q == ST_IDLE && !rd_go && wr_go) ||
                (state_q == ST_WRITE && wr_hold)) begin
                wdata_q <= data_s;
            end
            if (state_q == ST_FETCH) begin
                rdata_q <= reg_rdata_i;
            end
        end
    end

    // Outputs
    always_comb begin
        reg_rd_o    = 1'b0;
        reg_wr_o    = 1'b0;
        bus_oe_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  reg_rd_o = 1'b1;
            ST_READ:   bus_oe_o = 1'b1;
            ST_WRITE:  ;
            ST_COMMIT: reg_wr_o = 1'b1;
            default:   ;
        endcase
        reg_addr_o  = addr_q;
        reg_wdata_o = wdata_q;
        bus_data_o  = rdata_q;
    end

    assert_single_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);
    assert_single_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_o && reg_wr_o));
    assert_rd_then_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> bus_oe_o);
    assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> !bus_oe_o);
    assert_no_start_cs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !reg_rd_o);
    assert_drive_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_data_o));

endmodule

// File: rtl/hbus_irq_pin.sv
module hbus_irq_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_s,
    input  logic pending_i,
    input  logic gate_i,
    output logic drv_o,
    output logic oe_o
);

    always_comb begin
        if (mode_s) begin
            drv_o = pending_i;
            oe_o  = gate_i;
        end else begin
            drv_o = 1'b0;
            oe_o  = pending_i;
        end
    end

    assert_irq_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && !gate_i) |-> !oe_o);
    assert_irq_low_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && oe_o) |-> !drv_o);

endmodule

// File: rtl/hbus_host_port.sv
module hbus_host_port #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              irq_pending_i,
    input  logic              irq_gate_i,
    output logic              irq_drv_o,
    output logic              irq_oe_o
);

    localparam int SYNC_W = 4 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    logic [SYNC_W-1:0] raw_vec, sync_vec;
    logic              mode_s, cs_n_s, rd_n_s, wr_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;

    assign raw_vec = {bus_mode_i, cs_n_i, rd_n_i, wr_n_i, addr_i, data_i};
    assign {mode_s, cs_n_s, rd_n_s, wr_n_s, addr_s, data_s} = sync_vec;

    hbus_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    hbus_access_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_s      (mode_s),
        .cs_n_s      (cs_n_s),
        .rd_n_s      (rd_n_s),
        .wr_n_s      (wr_n_s),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .reg_rdata_i (reg_rdata_i),
        .reg_rd_o    (reg_rd_o),
        .reg_wr_o    (reg_wr_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .bus_data_o  (data_o),
        .bus_oe_o    (data_oe_o)
    );

    hbus_irq_pin u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (mode_s),
        .pending_i (irq_pending_i),
        .gate_i    (irq_gate_i),
        .drv_o     (irq_drv_o),
        .oe_o      (irq_oe_o)
    );

endmodule

// File: tb/hbus_host_port_tb_top.sv
module hbus_host_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_mode, cs_n, rd_n, wr_n;
    logic [2:0] addr;
    logic [7:0] data_in;
    logic [7:0] data_out;
    logic       data_oe, reg_rd, reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq_pending, irq_gate, irq_drv, irq_oe;

    logic [7:0] regs [8];
    int         n_chk = 0;
    int         n_fail = 0;
    int         rd_cnt = 0;
    int         wr_cnt = 0;
    logic [2:0] last_rd_addr, last_wr_addr;
    logic [7:0] last_wr_data;
    bit         done = 0;

    always #10 clk = ~clk;

    hbus_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .cs_n_i(cs_n),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr), .data_i(data_in),
        .data_o(data_out), .data_oe_o(data_oe), .reg_rd_o(reg_rd),
        .reg_wr_o(reg_wr), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata), .irq_pending_i(irq_pending),
        .irq_gate_i(irq_gate), .irq_drv_o(irq_drv), .irq_oe_o(irq_oe)
    );

    assign reg_rdata = regs[reg_addr];

    // Register file model and pulse monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_rd) begin
                rd_cnt++;
                last_rd_addr = reg_addr;
            end
            if (reg_wr) begin
                wr_cnt++;
                last_wr_addr = reg_addr;
                last_wr_data = reg_wdata;
                regs[reg_addr] <= reg_wdata;
            end
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        return regs[a];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        bus_mode = m;
        tick(4);
    endtask

    // R2 / R5 / R8: one read access in the current mode
    task automatic do_read(input logic [2:0] a, input int hold, input string tag);
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        logic [7:0] exp = model_read(a);
        addr = a;
        if (bus_mode) begin
            cs_n = 1'b0; tick(1); rd_n = 1'b0;
        end else begin
            wr_n = 1'b1; cs_n = 1'b0;
        end
        tick(5 + hold);
        chk({tag, " oe"}, data_oe, 1'b1);
        chk({tag, " data"}, data_out, exp);
        chk({tag, " pulses"}, rd_cnt - r0, 1);
        chk({tag, " addr"}, last_rd_addr, a);
        if (bus_mode) rd_n = 1'b1; else cs_n = 1'b1;
        tick(2);
        chk("R8 oe held", data_oe, 1'b1);
        tick(1);
        chk("R8 oe released", data_oe, 1'b0);
        cs_n = 1'b1;
        tick(3);
        chk("R11 single read", rd_cnt - r0, 1);
        chk("R11 no write on read", wr_cnt - w0, 0);
    endtask

    // R3 / R6 / R7: one write access in the current mode
    task automatic do_write(input logic [2:0] a, input logic [7:0] d, input int hold,
                            input bit poke_rd, input string tag);
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        addr = a; data_in = d;
        if (bus_mode) begin
            cs_n = 1'b0; tick(1); wr_n = 1'b0;
        end else begin
            wr_n = 1'b0; cs_n = 1'b0;
            if (poke_rd) rd_n = 1'b0;
        end
        tick(4 + hold);
        chk({tag, " no commit before end"}, wr_cnt - w0, 0);
        if (poke_rd) chk("R7 rd ignored, no drive", data_oe, 1'b0);
        if (bus_mode) wr_n = 1'b1; else cs_n = 1'b1;
        tick(1);
        data_in = ~d;
        rd_n = 1'b1;
        tick(5);
        chk({tag, " pulses"}, wr_cnt - w0, 1);
        chk({tag, " addr"}, last_wr_addr, a);
        chk({tag, " data"}, last_wr_data, d);
        chk("R11 no read on write", rd_cnt - r0, 0);
        if (poke_rd) chk("R7 no read pulse", rd_cnt - r0, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(2);
    endtask

    // R4: strobes with chip select high
    task automatic idle_strobes(input string tag);
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        cs_n = 1'b1;
        rd_n = 1'b0; tick(6); rd_n = 1'b1;
        wr_n = 1'b0; tick(6);
        chk({tag, " oe"}, data_oe, 1'b0);
        wr_n = 1'b1; tick(6);
        chk({tag, " rd"}, rd_cnt - r0, 0);
        chk({tag, " wr"}, wr_cnt - w0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_a11c));
        for (int i = 0; i < 8; i++) regs[i] = 8'(i * 37 + 5);
        rst_n = 1'b0; bus_mode = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr = '0; data_in = '0; irq_pending = 1'b0; irq_gate = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        chk("reset oe", data_oe, 1'b0);
        chk("reset rd", rd_cnt, 0);
        chk("reset wr", wr_cnt, 0);

        // Strobe mode (R1)
        do_read(3'd5, 0, "R2 strobe read");
        do_write(3'd2, 8'hA5, 0, 1'b0, "R3 strobe write");
        do_read(3'd2, 0, "R2 readback");
        do_write(3'd7, 8'h3C, 20, 1'b0, "R11 long strobe write");
        do_read(3'd0, 25, "R11 long strobe read");
        idle_strobes("R4 strobe mode");

        // R9: interrupt pin in strobe mode
        irq_pending = 1'b1; irq_gate = 1'b0; tick(1);
        chk("R9 tristate", irq_oe, 1'b0);
        irq_gate = 1'b1; tick(1);
        chk("R9 oe", irq_oe, 1'b1);
        chk("R9 high", irq_drv, 1'b1);
        irq_pending = 1'b0; tick(1);
        chk("R9 low", irq_drv, 1'b0);

        // Direction mode (R1)
        set_mode(1'b0);
        chk("R10 idle float", irq_oe, 1'b0);
        irq_pending = 1'b1; tick(1);
        chk("R10 pull", irq_oe, 1'b1);
        chk("R10 low", irq_drv, 1'b0);
        irq_gate = 1'b0; tick(1);
        chk("R10 gate ignored", irq_oe, 1'b1);
        irq_pending = 1'b0; tick(1);

        do_read(3'd5, 0, "R5 dir read");
        do_write(3'd4, 8'h96, 3, 1'b0, "R6 dir write");
        do_read(3'd4, 0, "R5 readback");
        do_write(3'd1, 8'h5A, 6, 1'b1, "R7 dir write rd low");
        idle_strobes("R4 dir mode");

        // Seeded random mix
        for (int k = 0; k < 60; k++) begin
            logic m = 1'($urandom);
            logic [2:0] a = 3'($urandom);
            logic [7:0] d = 8'($urandom);
            int h = int'($urandom_range(0, 8));
            if (m != bus_mode) set_mode(m);
            if ($urandom_range(0, 1) == 1) do_read(a, h, "R2 R5 random read");
            else do_write(a, d, h, 1'($urandom), "R3 R6 random write");
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule